// File: doc/BRIEF.md
# Event Counter Bank with Freeze-on-Interrupt

This block holds a set of programmable event counters. Some are general-purpose and some are fixed-function. Each counter advances by one on every clock cycle in which its event input is high, as long as it is enabled twice over: by its own control bit and by its bit in a shared global-enable register. Each counter can be set to request a monitoring interrupt when it wraps. An external buffer-threshold input can also raise that request, for example from a trace store or a sample store that is nearly full.

When the freeze option is set, each interrupt request clears the whole global-enable register in the same clock edge that raises the interrupt. Both kinds of counter therefore stop together, and none of them keeps counting past the event that caused the interrupt. Counting starts again only when software writes ones back into the global-enable register. Software reaches every register through a simple single-cycle write port and a combinational read port.

Top module: `perfmon_bank`

## Requirements
- R1: After reset every counter, control bit, global-enable bit, status bit, the freeze option and `irq_o` are zero, and every register reads zero.
- R2: A counter adds one on each clock edge at which its event input is high only if its local enable bit and its global-enable bit are both set. Otherwise it holds its value.
- R3: A counter at all-ones that is incremented wraps to zero and sets its sticky overflow status bit. The status register holds general-purpose counter g at bit g and fixed counter f at bit 16+f.
- R4: A status bit is cleared only by writing 1 to it at address 26. Writing 0 has no effect. If an overflow occurs in the same cycle as the clearing write, the bit stays set.
- R5: General-purpose counter g has its control word at address 8+g, with local enable at bit 0 and interrupt-on-overflow at bit 20. Its value is at address g. Its overflow drives `irq_o` high for exactly one cycle after the wrapping edge, but only if bit 20 is set.
- R6: The fixed counters share one control word at address 24, with a 4-bit field per counter starting at bit 4*f. Bit 0 of the field is the local enable and bit 3 is the interrupt-on-overflow. Fixed counter f has its value at address 16+f. An overflow of fixed counter f raises `irq_o` only if bit 3 of its field is set.
- R7: A cycle with `buf_thresh_i` high raises `irq_o` in the following cycle.
- R8: The freeze option is bit 12 of address 27. While it is set, any interrupt request clears every global-enable bit, for both general and fixed counters, at the same edge that raises `irq_o`. While it is clear, an interrupt request leaves the global-enable register unchanged. The global-enable register is at address 25, with general counter g at bit g and fixed counter f at bit 16+f.
- R9: If a software write to the global-enable register falls in the same cycle as a freeze, the freeze wins. Counting resumes only after a later write of ones.
- R10: A software write to a counter loads the written value. If the counter's event input is high in the same cycle, the write still wins and no increment or overflow results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gp_evt_i | input | NUM_GP | Per-cycle event inputs of the general-purpose counters |
| fx_evt_i | input | NUM_FX | Per-cycle event inputs of the fixed-function counters |
| buf_thresh_i | input | 1 | Buffer-threshold interrupt request |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Monitoring interrupt, one cycle per request |

## Verification
Two functions can land on the same edge: a freeze triggered by an interrupt request, and a software write that re-enables counting. The bench provokes this by pulsing the buffer threshold in exactly the cycle in which it writes all ones to the global-enable register. It then reads the register back and expects zero. A second collision pairs an overflow with a write-1 clear of that counter's status bit, and the bench judges the result by the bit still reading one. A third pairs a counter load with an event; the loaded value must appear unincremented.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int unsigned ADDR_W       = 5;
  localparam int unsigned DATA_W       = 32;
  // register addresses
  localparam int unsigned A_GP_CNT     = 0;
  localparam int unsigned A_GP_CTL     = 8;
  localparam int unsigned A_FX_CNT     = 16;
  localparam int unsigned A_FX_CTL     = 24;
  localparam int unsigned A_GLB_EN     = 25;
  localparam int unsigned A_OVF_STS    = 26;
  localparam int unsigned A_DBG_CTL    = 27;
  // field positions
  localparam int unsigned GP_EN_BIT    = 0;
  localparam int unsigned GP_INT_BIT   = 20;
  localparam int unsigned FX_FIELD_W   = 4;
  localparam int unsigned FX_EN_BIT    = 0;
  localparam int unsigned FX_INT_BIT   = 3;
  localparam int unsigned FX_FLAG_BASE = 16;
  localparam int unsigned FRZ_BIT      = 12;
endpackage

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en_i,
  input  logic             event_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] value_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bump;

  always_comb begin
    bump   = count_en_i & event_i;
    wrap_o = bump & (&cnt_q) & ~load_i;
    cnt_d  = cnt_q;
    if (load_i)    cnt_d = load_val_i;
    else if (bump) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign value_o = cnt_q;
endmodule

// File: rtl/perfmon_irq_ctrl.sv
module perfmon_irq_ctrl #(
  parameter int unsigned NCNT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCNT-1:0] ovf_int_i,
  input  logic            buf_thresh_i,
  output logic            req_o,
  output logic            irq_o
);
  logic irq_q, irq_d;

  always_comb begin
    req_o = (|ovf_int_i) | buf_thresh_i;
    irq_d = req_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/perfmon_bank.sv
module perfmon_bank
  import perfmon_pkg::*;
#(
  parameter int unsigned NUM_GP = 2,
  parameter int unsigned NUM_FX = 2,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_GP-1:0] gp_evt_i,
  input  logic [NUM_FX-1:0] fx_evt_i,
  input  logic              buf_thresh_i,
  input  logic              wr_en_i,
  input  logic [4:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int unsigned NCNT = NUM_GP + NUM_FX;

  logic [NCNT-1:0]            loc_en_q, loc_en_d;
  logic [NCNT-1:0]            int_en_q, int_en_d;
  logic [NCNT-1:0]            glb_q, glb_d;
  logic [NCNT-1:0]            sts_q, sts_d;
  logic                       frz_q, frz_d;
  logic [NCNT-1:0]            evt, wrap, load, wmap;
  logic [NCNT-1:0][CNT_W-1:0] cnt_v;
  logic                       req;
  logic [DATA_W-1:0]          glb_bus, sts_bus, fxctl_bus;
  logic                       unused_wdata;

  assign evt          = {fx_evt_i, gp_evt_i};
  assign unused_wdata = ^wdata_i;

  // bus bit -> internal counter index
  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp_map
    assign wmap[g] = wdata_i[g];
    assign load[g] = wr_en_i && (addr_i == ADDR_W'(A_GP_CNT + g));
  end
  for (genvar f = 0; f < NUM_FX; f++) begin : g_fx_map
    assign wmap[NUM_GP+f] = wdata_i[FX_FLAG_BASE+f];
    assign load[NUM_GP+f] = wr_en_i && (addr_i == ADDR_W'(A_FX_CNT + f));
  end

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    perfmon_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .count_en_i (loc_en_q[k] & glb_q[k]),
      .event_i    (evt[k]),
      .load_i     (load[k]),
      .load_val_i (wdata_i[CNT_W-1:0]),
      .value_o    (cnt_v[k]),
      .wrap_o     (wrap[k])
    );
  end

  perfmon_irq_ctrl #(.NCNT(NCNT)) u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ovf_int_i    (wrap & int_en_q),
    .buf_thresh_i (buf_thresh_i),
    .req_o        (req),
    .irq_o        (irq_o)
  );

  // next-state
  always_comb begin
    loc_en_d = loc_en_q;
    int_en_d = int_en_q;
    glb_d    = glb_q;
    sts_d    = sts_q;
    frz_d    = frz_q;
    if (wr_en_i) begin
      for (int g = 0; g < NUM_GP; g++) begin
        if (addr_i == ADDR_W'(A_GP_CTL + g)) begin
          loc_en_d[g] = wdata_i[GP_EN_BIT];
          int_en_d[g] = wdata_i[GP_INT_BIT];
        end
      end
      if (addr_i == ADDR_W'(A_FX_CTL)) begin
        for (int f = 0; f < NUM_FX; f++) begin
          loc_en_d[NUM_GP+f] = wdata_i[FX_FIELD_W*f + FX_EN_BIT];
          int_en_d[NUM_GP+f] = wdata_i[FX_FIELD_W*f + FX_INT_BIT];
        end
      end
      if (addr_i == ADDR_W'(A_GLB_EN))  glb_d = wmap;
      if (addr_i == ADDR_W'(A_OVF_STS)) sts_d = sts_q & ~wmap;
      if (addr_i == ADDR_W'(A_DBG_CTL)) frz_d = wdata_i[FRZ_BIT];
    end
    sts_d = sts_d | wrap;               // set beats clear
    if (req && frz_q) glb_d = '0;       // freeze beats software write
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_en_q <= '0;
      int_en_q <= '0;
      glb_q    <= '0;
      sts_q    <= '0;
      frz_q    <= 1'b0;
    end else begin
      loc_en_q <= loc_en_d;
      int_en_q <= int_en_d;
      glb_q    <= glb_d;
      sts_q    <= sts_d;
      frz_q    <= frz_d;
    end
  end

  // read path
  always_comb begin
    glb_bus   = '0;
    sts_bus   = '0;
    fxctl_bus = '0;
    for (int g = 0; g < NUM_GP; g++) begin
      glb_bus[g] = glb_q[g];
      sts_bus[g] = sts_q[g];
    end
    for (int f = 0; f < NUM_FX; f++) begin
      glb_bus[FX_FLAG_BASE+f]                = glb_q[NUM_GP+f];
      sts_bus[FX_FLAG_BASE+f]                = sts_q[NUM_GP+f];
      fxctl_bus[FX_FIELD_W*f + FX_EN_BIT]    = loc_en_q[NUM_GP+f];
      fxctl_bus[FX_FIELD_W*f + FX_INT_BIT]   = int_en_q[NUM_GP+f];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NUM_GP; g++) begin
      if (addr_i == ADDR_W'(A_GP_CNT + g)) rdata_o = DATA_W'(cnt_v[g]);
      if (addr_i == ADDR_W'(A_GP_CTL + g)) begin
        rdata_o[GP_EN_BIT]  = loc_en_q[g];
        rdata_o[GP_INT_BIT] = int_en_q[g];
      end
    end
    for (int f = 0; f < NUM_FX; f++) begin
      if (addr_i == ADDR_W'(A_FX_CNT + f)) rdata_o = DATA_W'(cnt_v[NUM_GP+f]);
    end
    if (addr_i == ADDR_W'(A_FX_CTL))  rdata_o = fxctl_bus;
    if (addr_i == ADDR_W'(A_GLB_EN))  rdata_o = glb_bus;
    if (addr_i == ADDR_W'(A_OVF_STS)) rdata_o = sts_bus;
    if (addr_i == ADDR_W'(A_DBG_CTL)) rdata_o[FRZ_BIT] = frz_q;
  end
endmodule

// File: rtl/perfmon_checks.sv
module perfmon_checks
  import perfmon_pkg::*;
#(
  parameter int unsigned NCNT  = 4,
  parameter int unsigned CNT_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       buf_thresh_i,
  input logic                       wr_en_i,
  input logic [4:0]                 addr_i,
  input logic                       req,
  input logic                       frz_q,
  input logic [NCNT-1:0]            glb_q,
  input logic [NCNT-1:0]            sts_q,
  input logic [NCNT-1:0][CNT_W-1:0] cnt_v,
  input logic                       irq_o
);
  p_freeze_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && frz_q) |=> (glb_q == '0));

  p_no_freeze_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !frz_q && !(wr_en_i && addr_i == ADDR_W'(A_GLB_EN))) |=> $stable(glb_q));

  p_thresh_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_thresh_i |=> irq_o);

  p_sticky_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == ADDR_W'(A_OVF_STS)) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  p_frozen_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_q == '0 && !wr_en_i) |=> $stable(cnt_v));
endmodule

bind perfmon_bank perfmon_checks #(.NCNT(NCNT), .CNT_W(CNT_W)) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .buf_thresh_i (buf_thresh_i),
  .wr_en_i      (wr_en_i),
  .addr_i       (addr_i),
  .req          (req),
  .frz_q        (frz_q),
  .glb_q        (glb_q),
  .sts_q        (sts_q),
  .cnt_v        (cnt_v),
  .irq_o        (irq_o)
);

// File: tb/perfmon_bank_bench.sv
module perfmon_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  gp_evt = '0;
  logic [1:0]  fx_evt = '0;
  logic        buf_thresh = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  int          irq_cnt = 0;
  bit          done = 1'b0;

  localparam logic [31:0] ALL_ON = 32'h0003_0003;

  always #10 clk = ~clk;

  perfmon_bank u_perfmon_bank (
    .clk(clk), .rst_n(rst_n), .gp_evt_i(gp_evt), .fx_evt_i(fx_evt),
    .buf_thresh_i(buf_thresh), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic events(input logic [1:0] g, input logic [1:0] f, input int n);
    gp_evt = g; fx_evt = f;
    repeat (n) @(negedge clk);
    gp_evt = '0; fx_evt = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 28; a++) begin
      rd(5'(a), d);
      chk("R1 reg", d, 32'h0);
    end
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_gating;
    logic [31:0] d;
    wr(5'd8, 32'h1);
    events(2'b11, 2'b00, 3);
    rd(5'd0, d); chk("R2 global off", d, 0);
    wr(5'd25, 32'h1);
    events(2'b11, 2'b00, 3);
    rd(5'd0, d); chk("R2 both on", d, 3);
    rd(5'd1, d); chk("R2 local off", d, 0);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    int c0;
    c0 = irq_cnt;
    wr(5'd0, 32'hFFFF_FFFE);
    events(2'b01, 2'b00, 2);
    rd(5'd0, d);  chk("R3 wrap", d, 0);
    rd(5'd26, d); chk("R3 status", d, 32'h1);
    @(negedge clk);
    chk("R5 no int without bit20", 32'(irq_cnt - c0), 0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    wr(5'd26, 32'h0);
    rd(5'd26, d); chk("R4 write0", d, 32'h1);
    wr(5'd26, 32'h1);
    rd(5'd26, d); chk("R4 write1 clears", d, 32'h0);
    wr(5'd9, 32'h1);
    wr(5'd25, 32'h3);
    wr(5'd1, 32'hFFFF_FFFF);
    gp_evt = 2'b10;
    wr(5'd26, 32'h2);
    gp_evt = '0;
    rd(5'd26, d); chk("R4 set beats clear", d, 32'h2);
    wr(5'd26, 32'hFFFF_FFFF);
  endtask

  task automatic t_freeze;
    logic [31:0] d;
    wr(5'd27, 32'h1000);
    wr(5'd8, 32'h0010_0001);
    wr(5'd9, 32'h1);
    wr(5'd24, 32'h11);
    wr(5'd0, 32'hFFFF_FFFF);
    wr(5'd1, 0); wr(5'd16, 0); wr(5'd17, 0);
    wr(5'd25, ALL_ON);
    events(2'b11, 2'b11, 1);
    chk("R5 irq after gp overflow", 32'(irq), 1);
    rd(5'd25, d); chk("R8 all enables cleared", d, 0);
    rd(5'd0, d);  chk("R3 gp0 wrapped", d, 0);
    events(2'b11, 2'b11, 2);
    chk("R5 irq one cycle", 32'(irq), 0);
    rd(5'd1, d);  chk("R8 gp1 frozen", d, 1);
    rd(5'd16, d); chk("R8 fx0 frozen", d, 1);
    wr(5'd25, ALL_ON);
    events(2'b10, 2'b10, 1);
    rd(5'd1, d);  chk("R9 gp1 resumes", d, 2);
    rd(5'd17, d); chk("R9 fx1 resumes", d, 2);
    wr(5'd26, 32'hFFFF_FFFF);
  endtask

  task automatic t_fixed;
    logic [31:0] d;
    int c0;
    wr(5'd27, 0);
    wr(5'd24, 32'h91);
    wr(5'd25, ALL_ON);
    c0 = irq_cnt;
    wr(5'd16, 32'hFFFF_FFFF);
    events(2'b00, 2'b01, 1);
    @(negedge clk);
    chk("R6 no int without bit3", 32'(irq_cnt - c0), 0);
    rd(5'd16, d); chk("R6 fx0 wrap", d, 0);
    rd(5'd26, d); chk("R3 fx0 status", d, 32'h0001_0000);
    wr(5'd17, 32'hFFFF_FFFF);
    events(2'b00, 2'b10, 1);
    chk("R6 fx1 irq", 32'(irq), 1);
    rd(5'd25, d); chk("R8 no freeze keeps enables", d, ALL_ON);
    rd(5'd24, d); chk("R6 ctl readback", d, 32'h91);
    wr(5'd26, 32'hFFFF_FFFF);
  endtask

  task automatic t_thresh;
    logic [31:0] d;
    wr(5'd27, 32'h1000);
    wr(5'd25, ALL_ON);
    buf_thresh = 1'b1;
    @(negedge clk);
    buf_thresh = 1'b0;
    chk("R7 thresh irq", 32'(irq), 1);
    rd(5'd25, d); chk("R8 thresh freeze", d, 0);
  endtask

  task automatic t_prio;
    logic [31:0] d;
    buf_thresh = 1'b1;
    wr(5'd25, ALL_ON);
    buf_thresh = 1'b0;
    rd(5'd25, d); chk("R9 freeze beats write", d, 0);
    wr(5'd25, ALL_ON);
    rd(5'd25, d); chk("R9 later write restores", d, ALL_ON);
  endtask

  task automatic t_load;
    logic [31:0] d;
    wr(5'd27, 0);
    wr(5'd8, 32'h1);
    gp_evt = 2'b01;
    wr(5'd0, 32'd100);
    gp_evt = '0;
    rd(5'd0, d); chk("R10 load wins", d, 100);
    events(2'b01, 2'b00, 1);
    rd(5'd0, d); chk("R10 counts after load", d, 101);
    wr(5'd0, 32'hFFFF_FFFF);
    gp_evt = 2'b01;
    wr(5'd0, 32'hFFFF_FFFF);
    gp_evt = '0;
    rd(5'd26, d); chk("R10 no overflow on load", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_gating;
    t_wrap;
    t_status;
    t_freeze;
    t_fixed;
    t_thresh;
    t_prio;
    t_load;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule